// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a serial-bus slave for a two-wire, open-drain bus (SMBus / I2C style) that runs from a fast system clock. It oversamples the bus lines. Both SCL and SDA pass through a two-flop synchronizer and a short glitch filter. Edges, start conditions and stop conditions are then detected on the cleaned lines. The slave address is seven bits. Its upper five bits are fixed at `01101` and its two low bits come from strap inputs.

In a write transfer, the first byte after the address is a command byte that loads an 8-bit register pointer. Each byte after that is stored at the pointer, and the pointer then steps by one. A read transfer carries no command byte. It returns bytes from wherever an earlier write left the pointer, and the pointer also steps after each byte. A small read/write register file sits at the bottom of the map. Four fixed identification registers sit at `0xF4`–`0xF7`. The SDA output is a single drive-low enable for an external open-drain pad.

The block has no data stream at its edge, so it has no valid/ready handshake. The strap inputs and the SDA drive are plain level signals.

Top module: `smbus_reg_slave`

## Requirements
- R1: After reset, `sda_drive_low` is 0, every read/write register holds 0x00 and the register pointer is 0x00.
- R2: A start condition is SDA falling while SCL is high. After it, the slave shifts in eight bits, MSB first. It matches the first seven bits against `0,1,1,0,1,addr_strap[1],addr_strap[0]`. Bit eight is the direction: 0 is write, 1 is read. On a match, the slave drives SDA low for the whole ninth (acknowledge) SCL pulse.
- R3: On an address mismatch, the slave does not acknowledge. It keeps SDA released for all later bytes until the next start condition.
- R4: In a write transfer, the first byte after the address is a command byte. It loads the register pointer and is acknowledged.
- R5: Each later write byte is acknowledged and stored at the pointer when the pointer is below `NREG` (default 8, addresses 0x00–0x07). The pointer then increments, wrapping at 0xFF.
- R6: A read transfer returns the byte at the pointer, MSB first, with no command byte. The pointer increments after each byte. The master acknowledges (SDA low on the ninth pulse) to get the next byte.
- R7: Addresses 0xF4, 0xF5, 0xF6 and 0xF7 read 0x41, 0x02, 0x00 and 0x00. Every other address at or above `NREG` reads 0x00. Writes to all of these are acknowledged but change nothing.
- R8: A master no-acknowledge (SDA high on the ninth pulse of a read byte) ends the transfer. The slave then keeps SDA released until a start or stop condition.
- R9: A stop condition is SDA rising while SCL is high. It returns the slave to idle from any point, including the middle of a byte. It leaves the pointer as the transfer left it.
- R10: A start condition inside a transfer (a repeated start) restarts address matching at once and keeps the pointer.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles (default 3) is ignored.
- R12: `sda_drive_low` changes only while the filtered SCL is low. The one exception is its release in the cycle after a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| addr_strap | input | 2 | Low two bits of the slave address |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench goes after the corner cases listed below.

- A mismatched address, including one that stops matching after the straps change. A slave that acknowledged it, or that woke up on a later byte, would show SDA pulled low while it should stay silent.
- A master no-acknowledge followed by further clock pulses. A slave that kept shifting data out would corrupt the bus and return something other than all-ones.
- A stop in the middle of an address byte, and a repeated start after a command byte. A design that kept stale bit counts would either miss the next address or read from a wrong pointer.
- A one-cycle glitch on SCL during a data bit. Without the filter, the bit count would gain a count and write-back would disagree.
- Writes to the identification registers and above the register file. A design that stored them would read back changed values.

// File: rtl/smbus_pkg.sv
package smbus_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_PREFIX = 5'b01101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_RDAT,
    ST_IGN
  } phase_e;

  function automatic logic [BYTE_W-1:0] id_value(input logic [BYTE_W-1:0] a);
    case (a)
      8'hF4:   return 8'h41;
      8'hF5:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbus_glitch_filter.sv
module smbus_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN + 1) : 1;

  logic           s1, s2;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      cnt  <= '0;
      dout <= 1'b1;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (int'(cnt) >= FILT_LEN - 1) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/smbus_cond_det.sv
module smbus_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smbus_regfile.sv
module smbus_regfile
  import smbus_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [BYTE_W-1:0] regs [NREG];
  logic              wr_in_range, rd_in_range;

  assign wr_in_range = ({24'd0, wr_addr} < NREG);
  assign rd_in_range = ({24'd0, rd_addr} < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && wr_in_range) begin
      regs[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_in_range ? regs[rd_addr[AW-1:0]] : id_value(rd_addr);
endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
  import smbus_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int NREG     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] addr_strap,
  output logic       sda_drive_low
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {scl_in, sda_in};

  generate
    for (genvar i = 0; i < NLINE; i++) begin : g_line
      smbus_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines[i]),
        .dout (filt_lines[i])
      );
    end
  endgenerate

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  smbus_cond_det u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_f),
    .sda     (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  phase_e            st;
  logic [3:0]        bitcnt;
  logic [6:0]        shreg;
  logic [6:0]        txreg;
  logic [BYTE_W-1:0] ptr;
  logic              ack_pend;
  logic              drv;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rd_data;
  logic              addr_hit;
  logic              wr_en;

  assign rx_byte  = {shreg, sda_f};
  assign addr_hit = (rx_byte[7:1] == {ADDR_PREFIX, addr_strap});
  assign wr_en    = scl_rise && (st == ST_WDAT) && (bitcnt == 4'd7)
                    && !start_ev && !stop_ev;

  smbus_regfile #(.NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(ptr),
    .wr_data(rx_byte),
    .rd_addr(ptr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      ack_pend <= 1'b0;
      drv      <= 1'b0;
    end else if (start_ev) begin
      st       <= ST_ADDR;
      bitcnt   <= '0;
      ack_pend <= 1'b0;
      drv      <= 1'b0;
    end else if (stop_ev) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      ack_pend <= 1'b0;
      drv      <= 1'b0;
    end else if (st == ST_IDLE || st == ST_IGN) begin
      drv <= 1'b0;
    end else if (scl_rise) begin
      if (bitcnt < 4'd8) begin
        shreg  <= rx_byte[6:0];
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == 4'd7) begin
          case (st)
            ST_ADDR: begin
              if (addr_hit) begin
                st       <= rx_byte[0] ? ST_RDAT : ST_CMD;
                ack_pend <= 1'b1;
              end else begin
                st       <= ST_IGN;
                ack_pend <= 1'b0;
              end
            end
            ST_CMD: begin
              ptr      <= rx_byte;
              st       <= ST_WDAT;
              ack_pend <= 1'b1;
            end
            ST_WDAT: begin
              ptr      <= ptr + 1'b1;
              ack_pend <= 1'b1;
            end
            ST_RDAT: begin
              ptr      <= ptr + 1'b1;
              ack_pend <= 1'b0;
            end
            default: ack_pend <= 1'b0;
          endcase
        end
      end else if (bitcnt == 4'd9 && st == ST_RDAT && sda_f) begin
        st <= ST_IGN;
      end
    end else if (scl_fall) begin
      if (bitcnt == 4'd8) begin
        drv    <= ack_pend;
        bitcnt <= 4'd9;
      end else if (bitcnt == 4'd9) begin
        bitcnt   <= '0;
        ack_pend <= 1'b0;
        if (st == ST_RDAT) begin
          txreg <= rd_data[6:0];
          drv   <= ~rd_data[7];
        end else begin
          drv <= 1'b0;
        end
      end else if (st == ST_RDAT && bitcnt != 4'd0) begin
        drv   <= ~txreg[6];
        txreg <= {txreg[5:0], 1'b0};
      end
    end
  end

  assign sda_drive_low = drv;
endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic drv
);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !drv);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !drv);

  // R12
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv) |-> (!scl_f || $past(start_ev) || $past(stop_ev)));

  // R2
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> $past(scl_fall));
endmodule

bind smbus_reg_slave smbus_reg_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .scl_fall(scl_fall),
  .start_ev(start_ev),
  .stop_ev (stop_ev),
  .drv     (sda_drive_low)
);

// File: tb/sim_smbus_reg_slave.sv
`timescale 1ns/1ps
module sim_smbus_reg_slave;
  localparam int NREG = 8;
  localparam int H    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_drive_low;
  wire  sda_bus = m_sda & ~sda_drive_low;

  always #2.5 clk = ~clk;

  smbus_reg_slave #(.FILT_LEN(3), .NREG(NREG)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (m_scl),
    .sda_in       (sda_bus),
    .addr_strap   (strap),
    .sda_drive_low(sda_drive_low)
  );

  int compared = 0, mismatched = 0;
  int q_cmp = 0, q_bad = 0;
  bit quiet = 1'b0;
  bit glitch_on = 1'b0;
  bit done = 1'b0;
  int ref_reg [256];
  int ref_ptr = 0;

  // per-clock comparison: while the model says the slave is silent
  always @(negedge clk) begin
    if (rst_n && quiet && !done) begin
      q_cmp++;
      if (sda_drive_low) begin
        q_bad++;
        $display("FAIL R3/R8/R9 quiet bus: actual drive=%0d expected=0 at %0t", sda_drive_low, $time);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_rd(input int p);
    if (p < NREG) return ref_reg[p];
    if (p == 8'hF4) return 8'h41;
    if (p == 8'hF5) return 8'h02;
    return 0;
  endfunction

  function automatic logic [7:0] abyte(input logic [1:0] s, input bit rw);
    return {5'b01101, s, rw};
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    quiet = 1'b0;
    m_sda = 1'b1; hold(H / 2);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H / 2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(H / 2);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(H);
    quiet = 1'b1;
  endtask

  task automatic send_bit(input bit b, input bit gl);
    m_sda = b; hold(H / 2);
    m_scl = 1'b1; hold(H / 2);
    if (gl) begin m_scl = 1'b0; hold(1); m_scl = 1'b1; end
    hold(H / 2);
    m_scl = 1'b0; hold(H / 2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch_on && i == 4);
    m_sda = 1'b1; hold(H / 2);
    m_scl = 1'b1; hold(H / 2);
    acked = !sda_bus;
    hold(H / 2);
    m_scl = 1'b0; hold(H / 2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H / 2);
      m_scl = 1'b1; hold(H / 2);
      b[i] = sda_bus;
      hold(H / 2);
      m_scl = 1'b0; hold(H / 2);
    end
    m_sda = mack ? 1'b0 : 1'b1; hold(H / 2);
    m_scl = 1'b1; hold(H);
    m_scl = 1'b0; hold(H / 2);
    m_sda = 1'b1;
  endtask

  task automatic wr_xfer(input logic [7:0] cmd, input logic [7:0] d0,
                         input logic [7:0] d1, input int n);
    bit a;
    bus_start();
    send_byte(abyte(strap, 1'b0), a); chk("R2 write address ack", a, 1);
    send_byte(cmd, a);                chk("R4 command ack", a, 1);
    ref_ptr = cmd;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = (k == 0) ? d0 : d1;
      send_byte(d, a); chk("R5 data ack", a, 1);
      if (ref_ptr < NREG) ref_reg[ref_ptr] = d;
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(tag, b, ref_rd(ref_ptr));
      ref_ptr = (ref_ptr + 1) % 256;
    end
  endtask

  task automatic rd_xfer(input int n, input string tag);
    bit a;
    bus_start();
    send_byte(abyte(strap, 1'b1), a); chk("R2 read address ack", a, 1);
    rd_bytes(n, tag);
    bus_stop();
  endtask

  task automatic set_ptr_rs_read(input logic [7:0] cmd, input int n, input string tag);
    bit a;
    bus_start();
    send_byte(abyte(strap, 1'b0), a); chk("R2 address ack", a, 1);
    send_byte(cmd, a);                chk("R4 command ack", a, 1);
    ref_ptr = cmd;
    bus_start();
    send_byte(abyte(strap, 1'b1), a); chk("R10 repeated-start address ack", a, 1);
    rd_bytes(n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + q_cmp, mismatched + q_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) ref_reg[i] = 0;
    hold(10);
    rst_n = 1'b1;
    hold(10);
    chk("R1 reset drive", sda_drive_low, 0);
    quiet = 1'b1;
    hold(50);

    // R1: pointer 0 and cleared registers
    rd_xfer(2, "R1 reset read");

    // R4 R5: write two bytes starting at 2
    wr_xfer(8'h02, 8'hA5, 8'h3C, 2);
    // R6: continue reading from the incremented pointer
    rd_xfer(2, "R6 read after write");
    // R10 + R6: set pointer then read back
    set_ptr_rs_read(8'h02, 2, "R6 read back");

    // R3: mismatched address, bus stays silent, nothing written
    bus_start();
    quiet = 1'b1;
    send_byte(abyte(2'b11, 1'b0), a); chk("R3 mismatch no ack", a, 0);
    send_byte(8'h02, a);              chk("R3 later byte no ack", a, 0);
    send_byte(8'hFF, a);              chk("R3 data no ack", a, 0);
    bus_stop();
    set_ptr_rs_read(8'h02, 1, "R3 register unchanged");

    // R7: identification registers
    set_ptr_rs_read(8'hF4, 4, "R7 id read");
    wr_xfer(8'hF4, 8'h77, 8'h55, 2);
    set_ptr_rs_read(8'hF4, 2, "R7 id write ignored");
    wr_xfer(8'h08, 8'h99, 8'h00, 1);
    set_ptr_rs_read(8'h08, 1, "R7 unmapped write ignored");

    // R5: pointer wrap from 0xFF to 0x00
    wr_xfer(8'hFF, 8'h11, 8'h6E, 2);
    set_ptr_rs_read(8'h00, 1, "R5 wrap write");

    // R8: master nack, then more clocks read as released bus
    set_ptr_rs_read(8'h02, 1, "R8 byte before nack");
    bus_start();
    send_byte(abyte(strap, 1'b1), a); chk("R8 address ack", a, 1);
    recv_byte(1'b0, b); chk("R8 nacked byte", b, ref_rd(ref_ptr));
    ref_ptr = (ref_ptr + 1) % 256;
    quiet = 1'b1;
    recv_byte(1'b1, b); chk("R8 bus released after nack", b, 8'hFF);
    bus_stop();

    // R9: stop after command keeps pointer; stop mid address byte
    bus_start();
    send_byte(abyte(strap, 1'b0), a); chk("R9 address ack", a, 1);
    send_byte(8'h03, a);              chk("R9 command ack", a, 1);
    ref_ptr = 8'h03;
    bus_stop();
    bus_start();
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    bus_stop();
    hold(200);
    rd_xfer(1, "R9 pointer kept after stops");

    // R11: one-cycle glitch on SCL during data bits
    glitch_on = 1'b1;
    wr_xfer(8'h05, 8'hC3, 8'h0F, 2);
    glitch_on = 1'b0;
    set_ptr_rs_read(8'h05, 2, "R11 glitch rejected");

    // R2 R3: strap change moves the address
    strap = 2'b01;
    hold(20);
    bus_start();
    quiet = 1'b1;
    send_byte(abyte(2'b10, 1'b0), a); chk("R3 old strap address no ack", a, 0);
    bus_stop();
    set_ptr_rs_read(8'h06, 1, "R2 new strap address");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + q_cmp, mismatched + q_bad);
    $finish;
  end
endmodule